// File: doc/BRIEF.md
# Per-Pin Edge Event Detector

This block sits behind the input sampling of one general-purpose I/O channel. It turns the channel's input word into a vector of per-pin edge events. Each pin has three controls: an enable bit, a rising-edge select and a falling-edge select. A pin with both selects set reports edges in either direction. The block holds a snapshot of the input word as it stood at the last evaluation. When the evaluate strobe arrives, each pin compares its current bit with its snapshot bit, and the edges that qualify are reported.

Software, or an upstream sequencer, pulses the evaluate strobe whenever it wants new events. The block also reloads the snapshot without reporting anything in two cases: when the reload strobe is pulsed, and on its own initiative when the channel goes from no enabled pins to at least one enabled pin. This stops stale history from creating spurious events at the moment a channel is armed.

Top module: `edge_event_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `eventVec` is all zeros and `anyEvent` is 0.
- R2: A pin whose data bit is 1, whose snapshot bit is 0, which is enabled and has its rising select set, reports a 1 in `eventVec` after an evaluation.
- R3: A pin whose data bit is 0, whose snapshot bit is 1, which is enabled and has its falling select set, reports a 1 in `eventVec` after an evaluation. An edge in the direction that is not selected reports 0.
- R4: With both selects set, a pin reports an edge in either direction. `eventVec` is the bitwise OR of the rising and falling results.
- R5: A pin whose enable bit is 0 never reports an event. Its snapshot bit still follows the data, so it reports no stale edge once it is enabled later.
- R6: Every evaluation overwrites the snapshot with the current data word. A second evaluation on unchanged data reports no events. Changes in the data between evaluations do not touch the snapshot.
- R7: A reload strobe copies the current data into the snapshot and reports no events. If a reload and an evaluate arrive in the same cycle, the reload takes effect and `eventVec` is zero.
- R8: In a cycle where the OR of `pinEnable` goes from 0 to 1, the snapshot is reloaded from the data, and any evaluation in that cycle reports no events.
- R9: `eventVec` is registered. It holds the result of an evaluation for exactly the one cycle after the evaluate strobe, and is zero in every other cycle.
- R10: `anyEvent` is 1 exactly when `eventVec` is nonzero, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dataIn | input | WIDTH | Sampled channel input word |
| pinEnable | input | WIDTH | Per-pin event enable |
| riseSel | input | WIDTH | Per-pin rising-edge select |
| fallSel | input | WIDTH | Per-pin falling-edge select |
| evalStrobe | input | 1 | Single-cycle request to compare the data with the snapshot |
| reloadStrobe | input | 1 | Single-cycle request to copy the data into the snapshot |
| eventVec | output | WIDTH | Per-pin event bits, valid for one cycle |
| anyEvent | output | 1 | OR of the event bits |

## Verification
The snapshot is the only state that cannot be seen directly. A wrong snapshot bit shows up at the ports only at the next evaluation that changes that pin, as a missing event or a spurious one. The bench therefore repeats evaluations after data changes, enable changes and reloads, so that a corrupted snapshot is caught within one or two strobes. A wrong enable-history flag shows up as events in the cycle a channel is armed, and this is visible in the cycle right after that strobe.

// File: rtl/edge_event_pkg.sv
package edge_event_pkg;
  typedef struct packed {
    logic loadSnap;
    logic doEval;
  } edgeCtrlT;
endpackage

// File: rtl/edge_event_ctrl.sv
module edge_event_ctrl
  import edge_event_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinEnable,
  input  logic             evalStrobe,
  input  logic             reloadStrobe,
  output edgeCtrlT         ctrl
);
  logic anyEnNow;
  logic anyEnPrev;
  logic armEdge;

  assign anyEnNow = |pinEnable;
  assign armEdge  = anyEnNow && !anyEnPrev;

  always_ff @(posedge clk) begin
    if (!rstN) anyEnPrev <= 1'b0;
    else       anyEnPrev <= anyEnNow;
  end

  // reload (explicit or on arming) beats evaluation
  always_comb begin
    ctrl.loadSnap = reloadStrobe || armEdge;
    ctrl.doEval   = evalStrobe && !ctrl.loadSnap;
  end

  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.loadSnap && ctrl.doEval));

  a_r8_arm_reload: assert property (@(posedge clk) disable iff (!rstN)
    (anyEnNow && !anyEnPrev) |-> ctrl.loadSnap);
endmodule

// File: rtl/edge_event_datapath.sv
module edge_event_datapath
  import edge_event_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  edgeCtrlT         ctrl,
  input  logic [WIDTH-1:0] dataIn,
  input  logic [WIDTH-1:0] pinEnable,
  input  logic [WIDTH-1:0] riseSel,
  input  logic [WIDTH-1:0] fallSel,
  output logic [WIDTH-1:0] eventVec,
  output logic             anyEvent
);
  logic [WIDTH-1:0] snapshot;
  logic [WIDTH-1:0] hitNow;

  for (genvar p = 0; p < WIDTH; p++) begin : g_pin
    logic rose;
    logic fell;
    assign rose      = dataIn[p] && !snapshot[p] && riseSel[p];
    assign fell      = !dataIn[p] && snapshot[p] && fallSel[p];
    assign hitNow[p] = pinEnable[p] && (rose || fell);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapshot <= '0;
      eventVec <= '0;
      anyEvent <= 1'b0;
    end else begin
      if (ctrl.loadSnap || ctrl.doEval) snapshot <= dataIn;
      if (ctrl.doEval) begin
        eventVec <= hitNow;
        anyEvent <= |hitNow;
      end else begin
        eventVec <= '0;
        anyEvent <= 1'b0;
      end
    end
  end

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.doEval |=> (eventVec == '0));

  a_r10_any_match: assert property (@(posedge clk) disable iff (!rstN)
    anyEvent == (eventVec != '0));

  a_r6_snap_follow: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.doEval || ctrl.loadSnap) |=> (snapshot == $past(dataIn)));

  a_r6_snap_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.doEval || ctrl.loadSnap) |=> $stable(snapshot));
endmodule

// File: rtl/edge_event_top.sv
module edge_event_top
  import edge_event_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dataIn,
  input  logic [WIDTH-1:0] pinEnable,
  input  logic [WIDTH-1:0] riseSel,
  input  logic [WIDTH-1:0] fallSel,
  input  logic             evalStrobe,
  input  logic             reloadStrobe,
  output logic [WIDTH-1:0] eventVec,
  output logic             anyEvent
);
  edgeCtrlT ctrl;

  edge_event_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .pinEnable(pinEnable),
    .evalStrobe(evalStrobe), .reloadStrobe(reloadStrobe), .ctrl(ctrl)
  );

  edge_event_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .dataIn(dataIn),
    .pinEnable(pinEnable), .riseSel(riseSel), .fallSel(fallSel),
    .eventVec(eventVec), .anyEvent(anyEvent)
  );

  a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((eventVec & ~$past(pinEnable)) == '0));

  a_r7_reload_quiet: assert property (@(posedge clk) disable iff (!rstN)
    reloadStrobe |=> (eventVec == '0));
endmodule

// File: tb/tb_edge_event_top.sv
module tb_edge_event_top;
  localparam int WIDTH = 32;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN;
  logic [WIDTH-1:0] dataIn, pinEnable, riseSel, fallSel;
  logic evalStrobe, reloadStrobe;
  logic [WIDTH-1:0] eventVec;
  logic anyEvent;

  int checks = 0;
  int errors = 0;
  logic [WIDTH-1:0] mSnap;
  logic mPrevAny;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_event_top #(.WIDTH(WIDTH)) dut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .pinEnable(pinEnable),
    .riseSel(riseSel), .fallSel(fallSel), .evalStrobe(evalStrobe),
    .reloadStrobe(reloadStrobe), .eventVec(eventVec), .anyEvent(anyEvent)
  );

  function automatic logic [WIDTH-1:0] refEvents(
    logic [WIDTH-1:0] d, logic [WIDTH-1:0] s, logic [WIDTH-1:0] en,
    logic [WIDTH-1:0] r, logic [WIDTH-1:0] f);
    return en & ((d & ~s & r) | (~d & s & f));
  endfunction

  task automatic checkOut(string tag, logic [WIDTH-1:0] expV);
    checks++;
    if (eventVec !== expV || anyEvent !== (expV != '0)) begin
      errors++;
      $display("FAIL %s: eventVec=%h anyEvent=%b expected %h anyEvent=%b",
               tag, eventVec, anyEvent, expV, (expV != '0));
    end
  endtask

  // drives one cycle (called at a negedge), updates the model, checks after the edge
  task automatic step(string tag, logic [WIDTH-1:0] d, logic [WIDTH-1:0] en,
                      logic [WIDTH-1:0] r, logic [WIDTH-1:0] f, logic ev, logic rl);
    logic [WIDTH-1:0] expV;
    logic armed;
    dataIn = d; pinEnable = en; riseSel = r; fallSel = f;
    evalStrobe = ev; reloadStrobe = rl;
    armed = (|en) && !mPrevAny;
    expV = '0;
    if (rl || armed) mSnap = d;
    else if (ev) begin
      expV = refEvents(d, mSnap, en, r, f);
      mSnap = d;
    end
    mPrevAny = |en;
    @(posedge clk);
    @(negedge clk);
    checkOut(tag, expV);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [WIDTH-1:0] ones;
    ones = '1;
    void'($urandom(32'd20240611));
    rstN = 1'b0; dataIn = '0; pinEnable = '0; riseSel = '0; fallSel = '0;
    evalStrobe = 1'b0; reloadStrobe = 1'b0;
    mSnap = '0; mPrevAny = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkOut("R1 in reset", '0);
    rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    checkOut("R1 after reset", '0);

    // R8: arming reloads the snapshot; an evaluation in the same cycle is silent
    step("R8 arm with eval", 32'h0000_00F0, ones, ones, '0, 1'b1, 1'b0);
    // R2: rising on newly set bits
    step("R2 rising", 32'h0000_0FF0, ones, ones, '0, 1'b1, 1'b0);
    // R6: unchanged data, second evaluation silent
    step("R6 repeat eval", 32'h0000_0FF0, ones, ones, '0, 1'b1, 1'b0);
    // R6: data changes without eval leave the snapshot alone
    step("R6 no eval", 32'h0000_0000, ones, ones, '0, 1'b0, 1'b0);
    step("R3 unselected fall", 32'h0000_0000, ones, ones, '0, 1'b1, 1'b0);
    // R3: falling only
    step("R3 setup", 32'h0000_00FF, ones, '0, ones, 1'b1, 1'b0);
    step("R3 falling", 32'h0000_000F, ones, '0, ones, 1'b1, 1'b0);
    step("R3 rising ignored", 32'h0000_F00F, ones, '0, ones, 1'b1, 1'b0);
    // R4: both edges
    step("R4 both", 32'hF000_0F00, ones, ones, ones, 1'b1, 1'b0);
    // R5: disabled pins quiet, but tracked
    step("R5 disabled", 32'h0F00_0F00, 32'h0000_FFFF, ones, ones, 1'b1, 1'b0);
    step("R5 enable later", 32'h0F00_0F00, ones, ones, ones, 1'b1, 1'b0);
    // R7: reload silent and wins over eval
    step("R7 reload", 32'h1234_5678, ones, ones, ones, 1'b0, 1'b1);
    step("R7 after reload", 32'h1234_5678, ones, ones, ones, 1'b1, 1'b0);
    step("R7 reload+eval", 32'hFFFF_0000, ones, ones, ones, 1'b1, 1'b1);
    step("R7 snapshot reloaded", 32'hFFFF_0000, ones, ones, ones, 1'b1, 1'b0);
    // R8: disarm then rearm with changed data
    step("R8 disarm", 32'h0000_0000, '0, ones, ones, 1'b1, 1'b0);
    step("R8 rearm", 32'hAAAA_AAAA, 32'h00FF_00FF, ones, ones, 1'b1, 1'b0);
    step("R8 after rearm", 32'h5555_5555, 32'h00FF_00FF, ones, ones, 1'b1, 1'b0);
    // R9: one-cycle pulse, then zero
    step("R9 pulse", 32'h0000_0000, ones, ones, ones, 1'b1, 1'b0);
    step("R9 idle after pulse", 32'hFFFF_FFFF, ones, ones, ones, 1'b0, 1'b0);

    // R4/R10: random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] sel;
      sel = 4'($urandom_range(15));
      step("R10 random", $urandom(),
           (sel == 0) ? '0 : ((sel < 4) ? $urandom() : ones),
           $urandom(), $urandom(), (sel != 5), (sel == 6));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule